// File: doc/BRIEF.md
# Bluetooth/WLAN Medium-Sharing Arbiter

This block decides when the local Bluetooth baseband may use the shared 2.4 GHz medium while a WLAN transceiver sits next to it. Four external lines run between the two radios, and their meaning depends on the active sharing scheme. In the arbitration scheme the block weighs requests from both sides. In the two blocking schemes one radio silences the other. In the two-wire scheme both blocking lines are present and software picks which side leads. In the alternating scheme the WLAN side marks, with a medium-free line, the windows that belong to Bluetooth.

The baseband presents a request together with its link type, and it marks packets in flight with a packet-active level. The block answers with a grant. A grant decision is only re-evaluated between packets. A single configuration write loads three things: the scheme, the master choice for two-wire mode, and a mask that marks which link types count as high priority.

Top module: `coex_arbiter`

## Requirements
- R1: After reset the scheme is arbitration (code 0), the grant is low, all line outputs are low, and the priority mask is 4'b0001, so link type 0 is high priority. A configuration write whose scheme code is above 4 leaves the scheme unchanged but still loads the mask and the master bit.
- R2: Scheme codes are 0 arbitration, 1 WLAN-leads, 2 Bluetooth-leads, 3 two-wire and 4 alternating. Lines 1..4 map to bits 0..3 of the line buses. `coex_oe` is 4'b0101 in scheme 0, 4'b0010 in schemes 2 and 3, and 4'b0000 otherwise. Line 4 is never driven, and no output bit is high while its enable is low.
- R3: In scheme 0, line 2 is the WLAN request input. A local request is granted when its link type is high priority (`prio_mask[link_type]` set), or when WLAN is not requesting. Line 1 is the confirm output: it is high when WLAN requests and the local side is not granted. Line 3 outputs "high-priority local request pending".
- R4: In scheme 1, line 1 is an input, and while it is high no local grant is given.
- R5: In scheme 2, line 2 outputs the local request, the grant follows the local request, and line 1 has no effect.
- R6: In scheme 3 with the master bit set, the block behaves as in scheme 2. With the master bit clear, line 1 blocks the grant as in scheme 1 and line 2 stays low.
- R7: In scheme 4, a local request is granted only while line 1 (medium free) is high.
- R8: While `bt_pkt_active` is high, the grant holds its value. A new decision is taken on the first edge at which it is low.
- R9: Line inputs pass through SYNC_STAGES flip-flops before they affect the grant. A configuration write takes effect at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Scheme code to load |
| cfg_bt_master | input | 1 | Two-wire mode: 1 means Bluetooth leads |
| cfg_prio_mask | input | 2**LINK_W | High-priority flag for each link type |
| bt_req | input | 1 | Local radio wants the medium |
| bt_link_type | input | LINK_W | Link type of the current request |
| bt_pkt_active | input | 1 | Local packet in flight |
| bt_grant | output | 1 | Local radio may use the medium |
| coex_in | input | 4 | Sampled levels of the four shared lines |
| coex_out | output | 4 | Values driven onto the shared lines |
| coex_oe | output | 4 | Drive enables for the shared lines |

## Verification
The bench builds the block with SYNC_STAGES=2 and LINK_W=2. This gives four link types, so every bit of the priority mask can be set or cleared by random writes. The settle window the bench waits after each stimulus is derived from SYNC_STAGES plus the output register. Random scheme, mask, master-bit, request and line patterns are checked against a bench model. Directed cases cover an illegal scheme code, a high-priority win over a WLAN request, and a grant held across a packet while the blocking line rises.

// File: rtl/coex_arbiter.sv
module coex_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int LINK_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_mode,
  input  logic                 cfg_bt_master,
  input  logic [2**LINK_W-1:0] cfg_prio_mask,
  input  logic                 bt_req,
  input  logic [LINK_W-1:0]    bt_link_type,
  input  logic                 bt_pkt_active,
  output logic                 bt_grant,
  input  logic [3:0]           coex_in,
  output logic [3:0]           coex_out,
  output logic [3:0]           coex_oe
);
  localparam int NTYPES = 2**LINK_W;
  localparam logic [2:0] M_PTA = 3'd0, M_WLM = 3'd1, M_BTM = 3'd2, M_TWO = 3'd3, M_ALT = 3'd4;

  logic [2:0]        mode_q;
  logic [NTYPES-1:0] prio_q;
  logic              btm_q;
  logic [3:0]        sync_q [SYNC_STAGES];
  logic [3:0]        pins_s;
  logic              want, grant_d, hi_prio;
  logic [3:0]        out_d, oe_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_PTA;
      prio_q <= NTYPES'(1);
      btm_q  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_mode <= M_ALT) mode_q <= cfg_mode;
      prio_q <= cfg_prio_mask;
      btm_q  <= cfg_bt_master;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= coex_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign pins_s  = sync_q[SYNC_STAGES-1];
  assign hi_prio = prio_q[bt_link_type];

  always_comb begin
    case (mode_q)
      M_PTA:   want = bt_req && (hi_prio || !pins_s[1]);
      M_WLM:   want = bt_req && !pins_s[0];
      M_BTM:   want = bt_req;
      M_TWO:   want = bt_req && (btm_q || !pins_s[0]);
      M_ALT:   want = bt_req && pins_s[0];
      default: want = 1'b0;
    endcase
  end

  assign grant_d = bt_pkt_active ? bt_grant : want;

  always_comb begin
    out_d = 4'b0000;
    oe_d  = 4'b0000;
    case (mode_q)
      M_PTA: begin
        oe_d  = 4'b0101;
        out_d = {1'b0, bt_req && hi_prio, 1'b0, pins_s[1] && !grant_d};
      end
      M_BTM: begin
        oe_d  = 4'b0010;
        out_d = {2'b00, bt_req, 1'b0};
      end
      M_TWO: begin
        oe_d  = 4'b0010;
        out_d = {2'b00, btm_q && bt_req, 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bt_grant <= 1'b0;
      coex_out <= 4'b0000;
      coex_oe  <= 4'b0101;
    end else begin
      bt_grant <= grant_d;
      coex_out <= out_d;
      coex_oe  <= oe_d;
    end

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n) mode_q <= M_ALT);
  assert_undriven_low_R2: assert property (@(posedge clk) disable iff (!rst_n) (coex_out & ~coex_oe) == 4'b0000);
  assert_line4_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) !coex_oe[3]);
  assert_confirm_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_oe[0] && coex_out[0]) |-> !bt_grant);
  assert_wlan_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WLM && pins_s[0] && !bt_pkt_active) |=> !bt_grant);
  assert_bt_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_BTM && !bt_pkt_active) |=> (bt_grant == $past(bt_req)));
  assert_alt_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ALT && !pins_s[0] && !bt_pkt_active) |=> !bt_grant);
  assert_hold_in_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bt_pkt_active |=> $stable(bt_grant));
endmodule

// File: tb/tb_coex_arbiter.sv
module tb_coex_arbiter;
  localparam int SS = 2;
  localparam int LW = 2;
  localparam int SETTLE = SS + 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_bt_master = 0;
  logic [2:0] cfg_mode = 0;
  logic [3:0] cfg_prio_mask = 0;
  logic bt_req = 0, bt_pkt_active = 0;
  logic [LW-1:0] bt_link_type = 0;
  logic [3:0] coex_in = 0;
  logic bt_grant;
  logic [3:0] coex_out, coex_oe;

  int checks = 0, fails = 0;
  logic [2:0] m_mode = 0;
  logic [3:0] m_mask = 4'b0001;
  logic m_btm = 0;

  always #2 clk = ~clk;

  coex_arbiter #(.SYNC_STAGES(SS), .LINK_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_bt_master(cfg_bt_master), .cfg_prio_mask(cfg_prio_mask),
    .bt_req(bt_req), .bt_link_type(bt_link_type), .bt_pkt_active(bt_pkt_active),
    .bt_grant(bt_grant), .coex_in(coex_in), .coex_out(coex_out), .coex_oe(coex_oe));

  function automatic logic exp_grant();
    logic hp = m_mask[bt_link_type];
    case (m_mode)
      0: return bt_req && (hp || !coex_in[1]);
      1: return bt_req && !coex_in[0];
      2: return bt_req;
      3: return bt_req && (m_btm || !coex_in[0]);
      4: return bt_req && coex_in[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] exp_oe();
    case (m_mode)
      0: return 4'b0101;
      2, 3: return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] exp_out(logic g);
    case (m_mode)
      0: return {1'b0, bt_req && m_mask[bt_link_type], 1'b0, coex_in[1] && !g};
      2: return {2'b00, bt_req, 1'b0};
      3: return {2'b00, m_btm && bt_req, 1'b0};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b mode=%0d", req, act, exp, m_mode);
    end
  endtask

  task automatic wr_cfg(logic [2:0] md, logic btm, logic [3:0] mask);
    @(negedge clk);
    cfg_we = 1; cfg_mode = md; cfg_bt_master = btm; cfg_prio_mask = mask;
    @(negedge clk);
    cfg_we = 0;
    if (md <= 4) m_mode = md;
    m_btm = btm; m_mask = mask;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  function automatic string req_of(logic [2:0] md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_all();
    logic g = exp_grant();
    chk(req_of(m_mode), {3'b0, bt_grant}, {3'b0, g});
    chk("R2", coex_oe, exp_oe());
    chk("R2", coex_out, exp_out(g));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {3'b0, bt_grant}, 4'b0000);
    chk("R1", coex_out, 4'b0000);
    chk("R1", coex_oe, 4'b0101);
    // R1 default mask: type 0 high priority beats WLAN request
    bt_req = 1; bt_link_type = 0; coex_in = 4'b0010;
    settle();
    chk("R1", {3'b0, bt_grant}, 4'b0001);
    bt_link_type = 1;
    settle();
    chk("R1", {3'b0, bt_grant}, 4'b0000);
    chk("R3", coex_out, 4'b0001);
    // R1 illegal scheme code ignored, mask still loaded
    wr_cfg(3'd6, 1'b0, 4'b0010);
    settle();
    chk("R1", coex_oe, 4'b0101);
    chk("R1", {3'b0, bt_grant}, 4'b0001);
    chk("R3", coex_out, 4'b0100);
    // R5 line 1 ignored in Bluetooth-leads scheme
    wr_cfg(3'd2, 1'b0, 4'b0001);
    coex_in = 4'b0001; bt_req = 1;
    settle();
    chk("R5", {3'b0, bt_grant}, 4'b0001);
    chk("R5", coex_out, 4'b0010);
    // R8 grant held over packet while line 1 blocks (WLAN-leads)
    wr_cfg(3'd1, 1'b0, 4'b0001);
    coex_in = 4'b0000; bt_req = 1;
    settle();
    chk("R4", {3'b0, bt_grant}, 4'b0001);
    bt_pkt_active = 1;
    @(negedge clk);
    coex_in = 4'b0001;
    settle();
    chk("R8", {3'b0, bt_grant}, 4'b0001);
    bt_pkt_active = 0;
    @(negedge clk);
    chk("R8", {3'b0, bt_grant}, 4'b0000);
    // R8 grant stays low during packet even if unblocked
    bt_pkt_active = 1;
    @(negedge clk);
    coex_in = 4'b0000;
    settle();
    chk("R8", {3'b0, bt_grant}, 4'b0000);
    bt_pkt_active = 0;
    // R9 sync latency: line change not seen before SS+1 edges
    wr_cfg(3'd4, 1'b0, 4'b0001);
    coex_in = 4'b0000; bt_req = 1;
    settle();
    @(negedge clk);
    coex_in = 4'b0001;
    repeat (SS) @(negedge clk);
    chk("R9", {3'b0, bt_grant}, 4'b0000);
    @(negedge clk);
    chk("R9", {3'b0, bt_grant}, 4'b0001);
    // R6 two-wire with both master choices
    wr_cfg(3'd3, 1'b0, 4'b0001);
    coex_in = 4'b0001; bt_req = 1;
    settle();
    chk("R6", {3'b0, bt_grant}, 4'b0000);
    chk("R6", coex_out, 4'b0000);
    wr_cfg(3'd3, 1'b1, 4'b0001);
    settle();
    chk("R6", {3'b0, bt_grant}, 4'b0001);
    chk("R6", coex_out, 4'b0010);
    // random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0)
        wr_cfg(3'($urandom_range(0, 5)), 1'($urandom), 4'($urandom));
      bt_req = 1'($urandom);
      bt_link_type = LW'($urandom);
      coex_in = 4'($urandom);
      settle();
      check_all();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule